// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets that a FIFO's partial-status logic compares against. One offset serves the almost-empty flag and the other serves the almost-full flag. The block does not compare anything itself. It only decides what the two offsets are and reports when they are final.

While full reset is asserted, the block reads a three-bit select code. Five of the codes pick a built-in default, which loads both offsets at once and makes them final straight away. The other codes leave the offsets at zero and wait for the user to program them. In serial programming, select bit 0 is the data bit and select bit 1 is the enable, and one bit is taken per enabled clock. In parallel programming, the first two enabled bus writes load the offsets.

After programming ends, bus writes pass through as data strobes. A partial reset freezes this block and never clears the loaded offsets. Only a new full reset picks a new configuration.

Top module: `flag_offset_loader`

## Requirements
- R1: Every clock edge at which rst_full_n is low samples sel, so the code held is the one on the last low edge. Codes 0, 1, 2, 3 and 4 load both offsets with 8, 16, 64, 256 and 1024 in that order, and they set prog_done on that same edge.
- R2: Code 5 selects serial programming and codes 6 and 7 select parallel programming. Either mode clears both offsets to 0 and holds prog_done low.
- R3: In serial mode, each edge with sel[1] high shifts sel[0] into the 32-bit chain {ofs_ae, ofs_af} from the least significant end. The result is that the first bit ends up as the MSB of ofs_ae.
- R4: In serial mode, prog_done rises on the edge that takes the 32nd enabled bit. Later serial bits change neither offset.
- R5: In serial mode, an edge with sel[1] low shifts nothing.
- R6: In parallel mode, the first edge with par_wr high loads par_data into ofs_ae. The second such edge loads par_data into ofs_af and sets prog_done.
- R7: data_wr is high in any cycle in which par_wr and prog_done are both high. Once prog_done is set, par_wr leaves both offsets unchanged.
- R8: While rst_part_n is low, serial and parallel programming inputs are ignored, and the offsets and prog_done keep their values.
- R9: Once prog_done is set, it and both offsets stay fixed until the next full reset. A new full reset takes effect with its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_full_n | input | 1 | Full reset, active low; samples the select code |
| rst_part_n | input | 1 | Partial reset, active low; holds the programming |
| sel | input | 3 | Select code during full reset; bit 0 is serial data and bit 1 is serial enable afterwards |
| par_wr | input | 1 | Parallel bus write strobe |
| par_data | input | OFS_W | Parallel bus data |
| ofs_ae | output | OFS_W | Almost-empty offset |
| ofs_af | output | OFS_W | Almost-full offset |
| prog_done | output | 1 | Offsets are final |
| data_wr | output | 1 | Bus write passed through as data |

## Verification
The hardest case is a serial stream that is interrupted many times before its 32nd bit. The interruptions include idle edges with the enable low and enabled edges blocked by partial reset, and the bit count must stay exact through all of them. The stimulus reaches this case with a seeded random generator. Before every real bit, it inserts a random number of enable-low gaps and blocked enabled edges. It then checks prog_done just before and just after the final bit, and shows that extra bits have no effect. Parallel trials follow the same pattern with blocked and idle writes, and each full reset draws a fresh random code.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_full_n,
  input  logic             rst_part_n,
  input  logic [2:0]       sel,
  input  logic             par_wr,
  input  logic [OFS_W-1:0] par_data,
  output logic [OFS_W-1:0] ofs_ae,
  output logic [OFS_W-1:0] ofs_af,
  output logic             prog_done,
  output logic             data_wr
);
  localparam int BITS  = 2 * OFS_W;
  localparam int CNT_W = $clog2(BITS + 1);

  typedef enum logic [1:0] {M_DEF, M_SER, M_PAR} mode_t;

  mode_t            mode;
  logic [CNT_W-1:0] cnt;

  function automatic logic [OFS_W-1:0] dflt(input logic [2:0] c);
    case (c)
      3'd0:    return OFS_W'(8);
      3'd1:    return OFS_W'(16);
      3'd2:    return OFS_W'(64);
      3'd3:    return OFS_W'(256);
      default: return OFS_W'(1024);
    endcase
  endfunction

  wire ser_shift = rst_part_n && (mode == M_SER) && !prog_done && sel[1];
  wire par_load  = rst_part_n && (mode == M_PAR) && !prog_done && par_wr;

  always_ff @(posedge clk) begin
    if (!rst_full_n) begin
      cnt <= '0;
      if (sel < 3'd5) begin
        mode      <= M_DEF;
        ofs_ae    <= dflt(sel);
        ofs_af    <= dflt(sel);
        prog_done <= 1'b1;
      end else begin
        mode      <= (sel == 3'd5) ? M_SER : M_PAR;
        ofs_ae    <= '0;
        ofs_af    <= '0;
        prog_done <= 1'b0;
      end
    end else if (ser_shift) begin
      {ofs_ae, ofs_af} <= {ofs_ae[OFS_W-2:0], ofs_af, sel[0]};
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(BITS - 1)) prog_done <= 1'b1;
    end else if (par_load) begin
      if (cnt == '0) ofs_ae <= par_data;
      else begin
        ofs_af    <= par_data;
        prog_done <= 1'b1;
      end
      cnt <= cnt + 1'b1;
    end
  end

  assign data_wr = par_wr & prog_done;

  AST_SER_LIMIT: assert property (@(posedge clk) disable iff (!rst_full_n) cnt <= CNT_W'(BITS)); // R4
  AST_DEF_MATCH: assert property (@(posedge clk) disable iff (!rst_full_n) (mode == M_DEF) |-> (ofs_ae == ofs_af) && prog_done); // R1
  AST_PART_HOLD: assert property (@(posedge clk) disable iff (!rst_full_n) !rst_part_n |=> $stable(ofs_ae) && $stable(ofs_af) && $stable(prog_done)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_full_n) prog_done |=> prog_done); // R9
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_full_n) prog_done |=> $stable(ofs_ae) && $stable(ofs_af)); // R7
endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_full_n = 1'b0, rst_part_n = 1'b1, par_wr = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [W-1:0] par_data = '0;
  logic [W-1:0] ofs_ae, ofs_af;
  logic prog_done, data_wr;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  flag_offset_loader #(.OFS_W(W)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [W-1:0] dflt_of(input int c);
    return W'(8) << ((c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : (c == 3) ? 5 : 7);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic full_reset(input int code);
    @(negedge clk);
    rst_full_n = 1'b0; rst_part_n = 1'b1; par_wr = 1'b0;
    sel = 3'($urandom_range(0, 7));
    @(negedge clk);
    sel = 3'(code);
    @(negedge clk);
    rst_full_n = 1'b1; sel = 3'd0;
    if (code < 5) begin
      check("R1 ae", ofs_ae, dflt_of(code));
      check("R1 af", ofs_af, dflt_of(code));
      check("R1 done", prog_done, 1);
    end else begin
      check("R2 ae", ofs_ae, 0);
      check("R2 af", ofs_af, 0);
      check("R2 done", prog_done, 0);
    end
  endtask

  task automatic noise();
    int g = $urandom_range(0, 3);
    for (int i = 0; i < g; i++) begin
      sel = {1'($urandom), 1'b0, 1'($urandom)};
      @(negedge clk);
    end
    if ($urandom_range(0, 3) == 0) begin
      rst_part_n = 1'b0; sel = {1'b0, 1'b1, 1'($urandom)};
      par_wr = 1'b1; par_data = W'($urandom);
      @(negedge clk);
      rst_part_n = 1'b1; par_wr = 1'b0; sel = 3'd0;
    end
  endtask

  task automatic serial_trial();
    logic [2*W-1:0] word = 32'($urandom);
    full_reset(5);
    for (int i = 0; i < 2*W; i++) begin
      noise();
      if (i == 2*W-1) check("R4 done before last bit", prog_done, 0);
      sel = {1'($urandom), 1'b1, word[2*W-1-i]};
      @(negedge clk);
      sel = 3'd0;
    end
    check("R3 ae", ofs_ae, word[2*W-1:W]);
    check("R3 af", ofs_af, word[W-1:0]);
    check("R4 done", prog_done, 1);
    for (int i = 0; i < 4; i++) begin
      sel = {1'b0, 1'b1, 1'($urandom)};
      @(negedge clk);
    end
    sel = 3'd0;
    check("R4 extra bits ae", ofs_ae, word[2*W-1:W]);
    check("R4 extra bits af", ofs_af, word[W-1:0]);
  endtask

  task automatic parallel_trial();
    logic [W-1:0] a = W'($urandom), b = W'($urandom);
    full_reset($urandom_range(6, 7));
    noise();
    par_wr = 1'b1; par_data = a;
    #1 check("R7 no data before done", data_wr, 0);
    @(negedge clk);
    par_wr = 1'b0;
    check("R6 ae", ofs_ae, a);
    check("R6 done after first", prog_done, 0);
    noise();
    par_wr = 1'b1; par_data = b;
    @(negedge clk);
    par_wr = 1'b0;
    check("R6 af", ofs_af, b);
    check("R6 ae kept", ofs_ae, a);
    check("R6 done", prog_done, 1);
    par_wr = 1'b1; par_data = ~b;
    #1 check("R7 data_wr", data_wr, 1);
    @(negedge clk);
    par_wr = 1'b0;
    #1 check("R7 data_wr low", data_wr, 0);
    check("R7 ae held", ofs_ae, a);
    check("R7 af held", ofs_af, b);
  endtask

  task automatic default_trial();
    int c = $urandom_range(0, 4);
    full_reset(c);
    rst_part_n = 1'b0;
    @(negedge clk);
    rst_part_n = 1'b1;
    check("R8 ae after partial reset", ofs_ae, dflt_of(c));
    par_wr = 1'b1; par_data = W'($urandom); sel = 3'b011;
    #1 check("R7 data_wr default", data_wr, 1);
    @(negedge clk);
    par_wr = 1'b0; sel = 3'd0;
    check("R9 ae fixed", ofs_ae, dflt_of(c));
    check("R9 af fixed", ofs_af, dflt_of(c));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 5; c++) full_reset(c);
    serial_trial();
    rst_part_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_part_n = 1'b1;
    check("R8 done held", prog_done, 1);
    full_reset(5);
    repeat (3) begin sel = 3'b001; @(negedge clk); end
    sel = 3'd0;
    check("R5 no shift ae", ofs_ae, 0);
    check("R5 no shift af", ofs_af, 0);
    for (int t = 0; t < 30; t++) begin
      case ($urandom_range(0, 2))
        0: serial_trial();
        1: parallel_trial();
        default: default_trial();
      endcase
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule